// File: doc/BRIEF.md
# Oversampled FSK Bit Averaging Filter

This block sits behind a 1-bit FSK demodulator and removes short disturbances from its output. On each sample strobe it shifts the raw demodulated bit into a sample history. It counts the ones in a window of the most recent samples and drives a majority decision as the filtered bit. The strobe rate and the window length depend on a 2-bit rate mode. The divider works in input clock cycles, so every rate scales with the clock frequency.

An enable input gives a power-down state. While the enable is low, the internal state is frozen and the output enable is deasserted, so the data pin can be tri-stated outside the block. When the enable rises, the block waits for one more clock edge before it applies an internal wake-up reset. That reset loads the sample history with an alternating pattern and drives the filtered bit low. The output enable is kept as a separate signal next to the data bit, so the chip-level pad can build the tri-state driver.

Top module: `fsk_bit_filter`

## Requirements
- R1: The sample strobe occurs once every 4 active cycles in mode 2'b00, once every 2 in mode 2'b01, and on every active cycle in modes 2'b10 and 2'b11. The first strobe falls on the last cycle of the first period after the wake-up reset.
- R2: The window length N is 6 in mode 2'b10 and 12 in every other mode. At a strobe edge, data_o becomes 1 if more than N/2 of the last N samples are 1, including the sample taken at that edge. It becomes 0 if fewer than N/2 are 1, and it keeps its value on a tie. Between strobes, data_o does not change.
- R3: While en_i is low, data_oe_o is low in the same cycle. No sample is taken and data_o stays at its last value.
- R4: After en_i rises, the wake-up reset is applied on the second rising clock edge at which en_i is sampled high. data_oe_o goes high after that edge and stays high while en_i remains high.
- R5: The wake-up reset loads the sample history so that entry i (0 = newest) holds 1 for odd i and 0 for even i. It also drives data_o to 0 and restarts the strobe divider.
- R6: A single inverted sample inside a bit is rejected. This holds for bits of 8 samples in mode 2'b10 and of 16 samples in the other modes: data_o at the end of each bit equals the bit value.
- R7: Entering or leaving mode 2'b01 happens only while en_i is low. Changes between the other modes while en_i is high take effect at the next edge without a reset.
- R8: While rst_ni is low, data_o and data_oe_o are low, and the block then waits for an enable rise before it starts filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| en_i | input | 1 | Enable; low selects power-down |
| mode_i | input | 2 | Rate mode select |
| data_i | input | 1 | Raw demodulated bit |
| data_o | output | 1 | Filtered bit |
| data_oe_o | output | 1 | Output enable for the data pin |

## Verification
On every cycle, the assertions check these rules: the block stays inactive while the enable is low, activation always follows two sampled-high enable edges, and the filtered bit never moves without a strobe or on a tie. They also check that the strobe spacing in the slowest mode is kept and that mode 2'b01 is never entered or left while enabled. Only the bench scenarios can show the majority value itself, the preset pattern and glitch rejection across real bit streams, since these depend on the sample history. The bench covers every mode, an on-the-fly change between modes 2'b10 and 2'b11, and power-down in the middle of a stream.

// File: rtl/fsk_filt_pkg.sv
package fsk_filt_pkg;
  localparam int unsigned WIN_LONG  = 12;
  localparam int unsigned WIN_SHORT = 6;
  localparam int unsigned DIV_W     = 2;
  localparam int unsigned WAKE_EDGES = 2;

  typedef enum logic [1:0] {
    MODE_SLOW  = 2'b00,
    MODE_MID   = 2'b01,
    MODE_FAST  = 2'b10,
    MODE_WIDE  = 2'b11
  } rate_mode_e;
endpackage

// File: rtl/fsk_wake_ctrl.sv
module fsk_wake_ctrl #(
  parameter int unsigned WAKE_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic active_o,
  output logic wake_rst_o
);
  localparam int unsigned CNT_W = (WAKE_EDGES > 1) ? $clog2(WAKE_EDGES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_EDGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  assign wake_rst_o = en_i && !active_q && (cnt_q == LAST);
  assign active_o   = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (wake_rst_o) active_q <= 1'b1;
      else            cnt_q    <= cnt_q + 1'b1;
    end
  end

  assert_off_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);

  assert_wake_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(en_i) && $past(en_i, 2)));
endmodule

// File: rtl/fsk_rate_div.sv
module fsk_rate_div #(
  parameter int unsigned DIV_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] mode_i,
  output logic       stb_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    unique case (mode_i)
      2'b00:   mask = DIV_W'(3);
      2'b01:   mask = DIV_W'(1);
      default: mask = '0;
    endcase
  end

  assign stb_o = run_i && (&(cnt_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_stb_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && mode_i == 2'b00) |=> (!stb_o || mode_i != 2'b00));
endmodule

// File: rtl/fsk_window_vote.sv
module fsk_window_vote #(
  parameter int unsigned WIN_LONG  = 12,
  parameter int unsigned WIN_SHORT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic stb_i,
  input  logic short_i,
  input  logic bit_i,
  output logic bit_o
);
  localparam int unsigned SUM_W = $clog2(WIN_LONG + 1);
  localparam logic [WIN_LONG-1:0] SHORT_MASK =
    {{(WIN_LONG-WIN_SHORT){1'b0}}, {WIN_SHORT{1'b1}}};

  function automatic logic [WIN_LONG-1:0] alt_pattern();
    logic [WIN_LONG-1:0] p;
    for (int i = 0; i < WIN_LONG; i++) p[i] = (i % 2) == 1;
    return p;
  endfunction

  localparam logic [WIN_LONG-1:0] PRESET = alt_pattern();

  logic [WIN_LONG-1:0] hist_q, hist_nxt, win_mask;
  logic [SUM_W-1:0]    sum;
  logic [SUM_W:0]      twice_sum, win_n;
  logic                above, below;

  assign hist_nxt = {hist_q[WIN_LONG-2:0], bit_i};
  assign win_mask = short_i ? SHORT_MASK : '1;
  assign win_n    = short_i ? (SUM_W+1)'(WIN_SHORT) : (SUM_W+1)'(WIN_LONG);

  always_comb begin
    sum = '0;
    for (int i = 0; i < WIN_LONG; i++)
      sum = sum + SUM_W'(hist_nxt[i] & win_mask[i]);
  end

  assign twice_sum = {sum, 1'b0};
  assign above     = twice_sum > win_n;
  assign below     = twice_sum < win_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= PRESET;
      bit_o  <= 1'b0;
    end else if (init_i) begin
      hist_q <= PRESET;
      bit_o  <= 1'b0;
    end else if (stb_i) begin
      hist_q <= hist_nxt;
      if (above)      bit_o <= 1'b1;
      else if (below) bit_o <= 1'b0;
    end
  end

  assert_tie_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !init_i && !above && !below) |=> $stable(bit_o));

  assert_no_stb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && !init_i) |=> $stable(bit_o));
endmodule

// File: rtl/fsk_bit_filter.sv
module fsk_bit_filter
  import fsk_filt_pkg::*;
#(
  parameter int unsigned WIN_L  = WIN_LONG,
  parameter int unsigned WIN_S  = WIN_SHORT,
  parameter int unsigned DIV_BW = DIV_W,
  parameter int unsigned WAKE_N = WAKE_EDGES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  input  logic       data_i,
  output logic       data_o,
  output logic       data_oe_o
);
  logic active, wake_rst, stb, short_win;

  assign short_win = (rate_mode_e'(mode_i) == MODE_FAST);

  fsk_wake_ctrl #(.WAKE_EDGES(WAKE_N)) u_wake (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .active_o  (active),
    .wake_rst_o(wake_rst)
  );

  fsk_rate_div #(.DIV_W(DIV_BW)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wake_rst),
    .run_i (active && en_i),
    .mode_i(mode_i),
    .stb_o (stb)
  );

  fsk_window_vote #(.WIN_LONG(WIN_L), .WIN_SHORT(WIN_S)) u_vote (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (wake_rst),
    .stb_i  (stb),
    .short_i(short_win),
    .bit_i  (data_i),
    .bit_o  (data_o)
  );

  assign data_oe_o = en_i && active;

  assert_mode01_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ((mode_i == 2'b01) == ($past(mode_i) == 2'b01)));
endmodule

// File: tb/tb_fsk_bit_filter.sv
module tb_fsk_bit_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       data_i = 1'b0;
  logic       data_o, data_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [11:0] m_hist;
  logic [1:0]  m_cnt;
  logic        m_out, m_act, m_seen;

  always #5 clk_i = ~clk_i;

  fsk_bit_filter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] preset_pat();
    logic [11:0] p;
    for (int i = 0; i < 12; i++) p[i] = i[0];
    return p;
  endfunction

  // one clock: drive, edge, update model, sample 2 ns later
  task automatic tick(input logic en, input logic [1:0] md, input logic d);
    logic [1:0] mask;
    int n, s;
    en_i = en; mode_i = md; data_i = d;
    @(posedge clk_i);
    if (!en) begin
      m_seen = 0; m_act = 0;
    end else if (!m_act) begin
      if (!m_seen) m_seen = 1;
      else begin
        m_act = 1; m_hist = preset_pat(); m_cnt = 0; m_out = 0;
      end
    end else begin
      mask = (md == 2'b00) ? 2'b11 : (md == 2'b01) ? 2'b01 : 2'b00;
      if ((m_cnt | ~mask) == 2'b11) begin
        m_hist = {m_hist[10:0], d};
        n = (md == 2'b10) ? 6 : 12;
        s = 0;
        for (int i = 0; i < n; i++) s += m_hist[i];
        if (2*s > n) m_out = 1;
        else if (2*s < n) m_out = 0;
      end
      m_cnt = m_cnt + 2'd1;
    end
    #2;
    chk("R3/R4 data_oe_o", data_oe_o, en && m_act);
    chk("R1/R2 data_o", data_o, m_out);
  endtask

  function automatic int div_of(input logic [1:0] md);
    return (md == 2'b00) ? 4 : (md == 2'b01) ? 2 : 1;
  endfunction

  // stream bits with one flipped sample per bit; check bit value at bit end
  task automatic stream(input logic [1:0] md, input logic [7:0] bits);
    int spb, dv;
    spb = (md == 2'b10) ? 8 : 16;
    dv = div_of(md);
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < spb; k++)
        for (int c = 0; c < dv; c++)
          tick(1'b1, md, (k == 4) ? ~bits[b] : bits[b]);
      if (b > 0) chk("R6 glitch rejected", data_o, bits[b]);
    end
  endtask

  task automatic wake(input logic [1:0] md);
    tick(1'b0, md, 1'b0);
    tick(1'b0, md, 1'b0);
    tick(1'b1, md, 1'b1);
    chk("R4 no oe after first edge", data_oe_o, 1'b0);
    tick(1'b1, md, 1'b1);
    chk("R4 oe after second edge", data_oe_o, 1'b1);
    chk("R5 data low after wake", data_o, 1'b0);
  endtask

  initial begin
    m_hist = preset_pat(); m_cnt = 0; m_out = 0; m_act = 0; m_seen = 0;
    #2;
    chk("R8 data_o in reset", data_o, 1'b0);
    chk("R8 data_oe_o in reset", data_oe_o, 1'b0);
    repeat (2) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    tick(1'b0, 2'b00, 1'b0);
    chk("R8 idle after reset", data_oe_o, 1'b0);

    // R5: preset pattern, mode 10 window of 6
    wake(2'b10);
    tick(1'b1, 2'b10, 1'b1);
    chk("R5 tie after preset", data_o, 1'b0);
    tick(1'b1, 2'b10, 1'b1);
    chk("R5 majority after preset", data_o, 1'b1);

    // R1: strobe spacing in mode 00
    wake(2'b00);
    tick(1'b1, 2'b00, 1'b1);
    tick(1'b1, 2'b00, 1'b1);
    tick(1'b1, 2'b00, 1'b1);
    chk("R1 no strobe before 4th cycle", data_o, 1'b0);

    foreach (mode_i[i]) ;
    for (int m = 0; m < 4; m++) begin
      wake(2'(m));
      stream(2'(m), 8'b0100_1011);
      stream(2'(m), 8'b1010_0101);
    end

    // R7: on-the-fly change 10 <-> 11
    wake(2'b11);
    stream(2'b11, 8'b0011_0110);
    stream(2'b10, 8'b1100_1001);
    stream(2'b11, 8'b0110_1101);

    // R3: power-down mid stream freezes output
    wake(2'b10);
    for (int k = 0; k < 12; k++) tick(1'b1, 2'b10, 1'b1);
    en_i = 1'b0;
    #1 chk("R3 oe drops with en", data_oe_o, 1'b0);
    for (int k = 0; k < 10; k++) tick(1'b0, 2'b10, 1'b0);
    chk("R3 data frozen", data_o, 1'b1);
    // change into 01 only while disabled (R7)
    tick(1'b0, 2'b01, 1'b0);
    wake(2'b01);
    stream(2'b01, 8'b1101_0010);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule